// File: doc/BRIEF.md
# Monitor Channel Response Transmitter

This block returns response bytes to a host over a framed monitor channel. It handles the transmit side of a two-wire handshake. An outgoing strobe bit (`up_mx_n`, active low) marks a byte as present. An incoming acknowledge bit (`dn_mr_n`, active low) comes back from the peer. The block is used when data has to travel back for a read command.

Bytes come from a simple valid/ready source, together with a flag that marks the last byte of the message. The block puts each byte on the channel and waits for the peer to acknowledge it. It then leaves one idle frame before the next byte. After the last byte it closes the message by leaving two idle frames.

The block also watches the downstream monitor byte. When the peer writes anything other than the all-ones filler, the block treats it as a collision and gives up. It also gives up when an acknowledge never arrives, and when the source has no byte ready in time. Each message ends with a one-cycle done pulse or a one-cycle abort pulse. All protocol state moves only on the one-cycle frame strobe.

Top module: `mon_tx`

## Requirements
- R1: After reset, and whenever no message is open, `up_mx_n` is 1, `up_mon` is 0xFF, and `tx_done` and `tx_abort` are 0. At a strobe with `src_valid` low, the block stays in this state.
- R2: `src_ready` is high only during a strobe cycle, and only when a byte can be taken. A byte offered at a strobe in the idle state is accepted at that strobe. From the clock after that strobe, `up_mx_n` is 0 and `up_mon` carries the byte.
- R3: A byte stays on `up_mon` with `up_mx_n` at 0 until a strobe at which two things hold: `dn_mr_n` is 1, and `dn_mr_n` was 0 at the previous strobe of that byte. Because of this rule, every byte is driven for at least two frames.
- R4: After an acknowledge of a byte whose last flag is 0, the block drives `up_mx_n` = 1 and `up_mon` = 0xFF for exactly one frame. It then accepts the next byte at the following strobe and drives it.
- R5: After an acknowledge of the byte whose last flag is 1, the block drives two idle frames. `tx_done` then pulses in the clock cycle after the second strobe following the acknowledge.
- R6: A strobe at which a message is open and `dn_mon` is not 0xFF aborts the message. This applies whether the block is sending a byte, in the gap frame, or in the closing frames.
- R7: A byte that is not acknowledged by the 16th strobe after it was first driven aborts the message at that 16th strobe. An acknowledge at that same strobe still counts.
- R8: In the gap frame after a non-last byte, if `src_valid` is low at the strobe, the message aborts.
- R9: `up_mx_n` and `up_mon` change only on the clock edge at which `frame_stb` is high.
- R10: `tx_done` and `tx_abort` are single-cycle pulses and never high together. On an abort, the outputs return to the idle values of R1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_stb | input | 1 | One-cycle pulse once per frame |
| src_valid | input | 1 | Source has a byte |
| src_data | input | 8 | Source byte |
| src_last | input | 1 | Source byte ends the message |
| src_ready | output | 1 | Byte taken this cycle when valid |
| dn_mr_n | input | 1 | Peer acknowledge bit, active low |
| dn_mon | input | 8 | Peer monitor byte |
| up_mx_n | output | 1 | Outgoing byte-present bit, active low |
| up_mon | output | 8 | Outgoing monitor byte |
| tx_done | output | 1 | Message completed pulse |
| tx_abort | output | 1 | Message abandoned pulse |

## Verification
The bench sweeps message lengths against acknowledge delays. For each pair it predicts the exact strobe of every byte, gap and done pulse. A design that advanced on the acknowledge level instead of its falling edge, or skipped the gap frame, would shift every later byte.

Collisions are injected at each byte position. Underruns are forced in each gap. A design that ignored these would run to a done pulse instead of aborting.

The acknowledge delay is also run one frame inside the timeout limit and one frame past it. An off-by-one timeout counter would abort the first case or complete the second.

// File: rtl/mon_tx_pkg.sv
// Shared types for the monitor channel transmitter.
package mon_tx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,  // no message open, filler on the channel
        ST_SEND = 2'd1,  // byte driven, waiting for acknowledge
        ST_GAP  = 2'd2,  // one inactive frame after an acknowledge
        ST_EOM  = 2'd3   // second inactive frame closing the message
    } mon_tx_state_e;
endpackage

// File: rtl/mon_tx_ackdet.sv
// Acknowledge and timeout detector.
// Counts strobes while a byte is driven and remembers the acknowledge bit
// seen at the previous strobe. An acknowledge is an active-to-inactive
// transition seen across two strobes of the same byte, and only after the
// minimum hold time. Assumes that load pulses only together with frame_stb.
module mon_tx_ackdet #(
    parameter int MIN_HOLD = 2,
    parameter int TIMEOUT  = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_stb,
    input  logic load,
    input  logic sending,
    input  logic dn_mr_n,
    output logic ack,
    output logic timeout
);
    localparam int CW = $clog2(TIMEOUT + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(TIMEOUT - 1);
    localparam logic [CW-1:0] CNT_HOLD = CW'(MIN_HOLD - 1);

    logic          mr_prev;
    logic [CW-1:0] fcnt;

    // Track the previous acknowledge level and the frames spent on this byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mr_prev <= 1'b0;
            fcnt    <= '0;
        end else if (frame_stb) begin
            if (load || !sending) begin
                mr_prev <= 1'b0;
                fcnt    <= '0;
            end else begin
                mr_prev <= !dn_mr_n;
                if (fcnt != CNT_LAST) fcnt <= fcnt + 1'b1;
            end
        end
    end

    // Falling-activity edge of the acknowledge after the minimum hold.
    always_comb ack = frame_stb && sending && mr_prev && dn_mr_n && (fcnt >= CNT_HOLD);

    // Limit reached with no acknowledge so far.
    always_comb timeout = frame_stb && sending && (fcnt == CNT_LAST);

    p_count_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fcnt <= CNT_LAST)
        else $error("frame counter beyond limit");
endmodule

// File: rtl/mon_tx_datapath.sv
// Byte holding register and channel output mux.
// Captures the source byte and its last flag on load. Drives the held
// byte with the strobe bit active while sending, and all-ones filler with
// the strobe bit inactive otherwise.
module mon_tx_datapath #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] src_data,
    input  logic         src_last,
    input  logic         sending,
    output logic         last_q,
    output logic         up_mx_n,
    output logic [W-1:0] up_mon
);
    localparam logic [W-1:0] FILLER = {W{1'b1}};

    logic [W-1:0] byte_q;

    // Hold the byte being transmitted and whether it closes the message.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_q <= FILLER;
            last_q <= 1'b0;
        end else if (load) begin
            byte_q <= src_data;
            last_q <= src_last;
        end
    end

    // Select held byte or filler onto the channel.
    always_comb begin
        up_mx_n = !sending;
        up_mon  = sending ? byte_q : FILLER;
    end
endmodule

// File: rtl/mon_tx.sv
// Monitor channel response transmitter (top).
// Sequences bytes through the send, gap and closing frames. Aborts on a
// collision, on an acknowledge timeout, or when the source runs dry in
// mid-message. All state moves on frame_stb. Assumes that frame_stb is a
// single-cycle pulse and that the source holds its byte until it is taken.
module mon_tx
    import mon_tx_pkg::*;
#(
    parameter int W        = 8,
    parameter int MIN_HOLD = 2,
    parameter int TIMEOUT  = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         frame_stb,
    input  logic         src_valid,
    input  logic [W-1:0] src_data,
    input  logic         src_last,
    output logic         src_ready,
    input  logic         dn_mr_n,
    input  logic [W-1:0] dn_mon,
    output logic         up_mx_n,
    output logic [W-1:0] up_mon,
    output logic         tx_done,
    output logic         tx_abort
);
    localparam logic [W-1:0] FILLER = {W{1'b1}};

    mon_tx_state_e state_q, state_d;
    logic          load, sending, last_q, ack, timeout, collide;
    logic          fire_done, fire_abort;

    always_comb sending = (state_q == ST_SEND);
    always_comb collide = (state_q != ST_IDLE) && (dn_mon != FILLER);

    // Source handshake: only on a strobe, in idle or in a gap that expects more.
    always_comb src_ready = frame_stb &&
        ((state_q == ST_IDLE) || ((state_q == ST_GAP) && !last_q));
    always_comb load = src_ready && src_valid;

    mon_tx_ackdet #(.MIN_HOLD(MIN_HOLD), .TIMEOUT(TIMEOUT)) i_ackdet (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_stb (frame_stb),
        .load      (load),
        .sending   (sending),
        .dn_mr_n   (dn_mr_n),
        .ack       (ack),
        .timeout   (timeout)
    );

    mon_tx_datapath #(.W(W)) i_datapath (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .src_data (src_data),
        .src_last (src_last),
        .sending  (sending),
        .last_q   (last_q),
        .up_mx_n  (up_mx_n),
        .up_mon   (up_mon)
    );

    // Next-state decision at each strobe; collision outranks acknowledge and timeout.
    always_comb begin
        state_d    = state_q;
        fire_done  = 1'b0;
        fire_abort = 1'b0;
        if (frame_stb) begin
            unique case (state_q)
                ST_IDLE: if (src_valid) state_d = ST_SEND;
                ST_SEND: begin
                    if (collide)      begin state_d = ST_IDLE; fire_abort = 1'b1; end
                    else if (ack)     state_d = ST_GAP;
                    else if (timeout) begin state_d = ST_IDLE; fire_abort = 1'b1; end
                end
                ST_GAP: begin
                    if (collide)        begin state_d = ST_IDLE; fire_abort = 1'b1; end
                    else if (last_q)    state_d = ST_EOM;
                    else if (src_valid) state_d = ST_SEND;
                    else                begin state_d = ST_IDLE; fire_abort = 1'b1; end
                end
                ST_EOM: begin
                    state_d = ST_IDLE;
                    if (collide) fire_abort = 1'b1;
                    else         fire_done  = 1'b1;
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // Register the state and the one-cycle result pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            tx_done  <= 1'b0;
            tx_abort <= 1'b0;
        end else begin
            state_q  <= state_d;
            tx_done  <= fire_done;
            tx_abort <= fire_abort;
        end
    end

    p_ack_while_driving_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> !up_mx_n)
        else $error("acknowledge taken with no byte driven");

    p_done_after_idle_frame_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |-> $past(up_mx_n))
        else $error("done without a closing inactive frame");

    p_abort_to_filler_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_abort |-> (up_mx_n && (up_mon == FILLER)))
        else $error("abort left the channel driven");

    p_outputs_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_stb |=> ($stable(up_mx_n) && $stable(up_mon)))
        else $error("channel output moved between strobes");

    p_pulses_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_done && tx_abort))
        else $error("done and abort together");
endmodule

// File: tb/test_mon_tx.sv
// Sweeping bench: models the peer per frame and predicts every strobe arithmetically.
module test_mon_tx;
    localparam int CLK_PERIOD = 10;
    localparam int FR = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_stb = 1'b0;
    logic       src_valid = 1'b0;
    logic [7:0] src_data = 8'h00;
    logic       src_last = 1'b0;
    logic       src_ready;
    logic       dn_mr_n = 1'b1;
    logic [7:0] dn_mon = 8'hFF;
    logic       up_mx_n;
    logic [7:0] up_mon;
    logic       tx_done, tx_abort;

    int errors = 0;
    int checks = 0;
    logic took;
    logic o_mx, o_done, o_abort;
    logic [7:0] o_mon;

    always #(CLK_PERIOD/2) clk = ~clk;

    mon_tx i_mon_tx (
        .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb),
        .src_valid(src_valid), .src_data(src_data), .src_last(src_last),
        .src_ready(src_ready), .dn_mr_n(dn_mr_n), .dn_mon(dn_mon),
        .up_mx_n(up_mx_n), .up_mon(up_mon), .tx_done(tx_done), .tx_abort(tx_abort)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] bval(input int i, input int d);
        return 8'(8'h11 * (i + 1) + d);
    endfunction

    // One frame: strobe, sample outputs, confirm pulses end and outputs hold (R9, R10).
    task automatic step();
        frame_stb = 1'b1;
        #1 took = src_ready && src_valid;
        @(posedge clk);
        @(negedge clk);
        frame_stb = 1'b0;
        o_mx = up_mx_n; o_mon = up_mon; o_done = tx_done; o_abort = tx_abort;
        @(negedge clk);
        chk(!tx_done && !tx_abort, "R10 pulse width", {tx_done, tx_abort}, 0);
        chk(src_ready == 1'b0, "R2 ready off strobe", src_ready, 0);
        repeat (FR - 2) @(negedge clk);
        chk(up_mx_n == o_mx && up_mon == o_mon, "R9 hold between strobes",
            {up_mx_n, up_mon}, {o_mx, o_mon});
    endtask

    task automatic idle_frames(input int k);
        src_valid = 1'b0; dn_mr_n = 1'b1; dn_mon = 8'hFF;
        for (int i = 0; i < k; i++) begin
            step();
            chk(o_mx && o_mon == 8'hFF && !o_done && !o_abort, "R1 idle",
                {o_mx, o_mon, o_done, o_abort}, {1'b1, 8'hFF, 2'b00});
        end
    endtask

    // mode 0: normal or timeout, 1: collision on byte 'at', 2: source runs dry after byte 'at'
    task automatic run(input int n, input int d, input int mode, input int at);
        int idx = 0;
        int j = 0;
        int avail, end_t, k, r;
        bit is_done, send;
        logic [7:0] eb;
        string tag, etag;
        avail = (mode == 2) ? at + 1 : n;
        if (mode == 1)               begin end_t = at * (d + 2) + 1;     is_done = 0; etag = "R6 collision abort"; end
        else if (mode == 2)          begin end_t = at * (d + 2) + d + 2; is_done = 0; etag = "R8 underrun abort"; end
        else if (d == 0 || d >= 16)  begin end_t = 16;                   is_done = 0; etag = "R7 timeout abort"; end
        else begin end_t = (n - 1) * (d + 2) + d + 3; is_done = 1; etag = "R5 done pulse"; end
        for (int t = 0; t <= end_t; t++) begin
            src_valid = (idx < avail);
            src_data  = bval(idx, d);
            src_last  = (idx == n - 1);
            dn_mr_n   = !(j >= 1 && j <= d);
            dn_mon    = (mode == 1 && idx == at + 1 && j == 1) ? 8'h5A : 8'hFF;
            step();
            if (took) idx++;
            k = t / (d + 2);
            r = t % (d + 2);
            if (t == end_t)                        begin send = 0; eb = 8'hFF; end
            else if (mode == 0 && !is_done)        begin send = 1; eb = bval(0, d); end
            else begin send = (r <= d) && (k < n); eb = bval(k, d); end
            if (t == 0)      tag = "R2 first byte";
            else if (send)   tag = "R3 byte held";
            else if (k < n && t != end_t) tag = "R4 gap frame";
            else             tag = "R5 closing frame";
            chk(o_mx == !send && o_mon == (send ? eb : 8'hFF), tag,
                {o_mx, o_mon}, {!send, (send ? eb : 8'hFF)});
            chk(o_done == (t == end_t && is_done) && o_abort == (t == end_t && !is_done),
                (t == end_t) ? etag : "R10 no early pulse",
                {o_done, o_abort}, {(t == end_t && is_done), (t == end_t && !is_done)});
            if (o_mx == 1'b0) j++; else j = 0;
        end
        idle_frames(2);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(up_mx_n && up_mon == 8'hFF && !tx_done && !tx_abort, "R1 reset state",
            {up_mx_n, up_mon, tx_done, tx_abort}, {1'b1, 8'hFF, 2'b00});
        idle_frames(3);
        for (int n = 1; n <= 3; n++)
            for (int d = 1; d <= 3; d++)
                run(n, d, 0, 0);
        run(1, 15, 0, 0);   // acknowledge at the last allowed strobe (R7)
        run(2, 16, 0, 0);   // acknowledge one frame too late (R7)
        run(2, 0, 0, 0);    // acknowledge never raised (R3, R7)
        for (int c = 0; c < 3; c++) run(3, 2, 1, c);
        for (int u = 0; u < 2; u++) run(3, 1, 2, u);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule